// File: doc/BRIEF.md
# Latched Indirect Interrupt-Table Window

This block sits in front of an 8-byte register pair inside a device's register space. It intercepts the indirect path that software uses to reach an interrupt vector table. Software first writes a command word to the address register at window offset 4, then moves data through the data register at window offset 0. When the type field of the command word names the vector table, the block takes over the pair. Reads of the data register then come from the table port. An address write with its top bit set copies the value last written to the data register into the table, and that command never reaches the real device. For any other type, the block steps aside and every access goes to the downstream target unchanged.

The controller has two states. `ST_PASS` is the reset state, in which everything passes through. `ST_LATCHED` is entered on any address-register write whose type field equals 1 (transition *claim*). It is left on an address-register write with any other type (transition *release*) or on reset. All other requests keep the current state (transition *hold*). Each accepted request produces a response in the next cycle. A downstream read must return its data in the same cycle that `ds_valid` is asserted, and so must a table read with `tbl_re`.

Top module: `idx_tbl_window`

## Requirements
- R1: The data register sits at window offset 0 and the address register at offset 4. In the address word, bits 11:0 are the table index, bits 15:12 are ignored, bits 30:16 are the type, and bit 31 is the command/latch flag.
- R2: An address-register write whose type is 1 enters `ST_LATCHED` and stores the whole 32-bit word. If bit 31 is clear, the write is also forwarded downstream.
- R3: An address-register write whose type is 1 and whose bit 31 is set writes the stored data value into the table at index bits 11:0 of the written word. This write is not forwarded downstream.
- R4: An address-register write with any type other than 1 enters `ST_PASS` and is forwarded downstream.
- R5: In `ST_LATCHED`, a read of the address register returns the stored word with bit 31 inverted and is not forwarded.
- R6: In `ST_LATCHED`, a read of the data register returns the table entry at index bits 11:0 of the stored word and is not forwarded.
- R7: A write to the data register stores its value for later table writes and is always forwarded downstream.
- R8: In `ST_PASS`, reads of either register are forwarded, and the response carries the downstream read data.
- R9: A request that is not a full 32-bit access, or whose offset is not a multiple of 4, gets an error response with zero data. Such a request changes no state, is not forwarded and does not touch the table.
- R10: When `tbl_present` is low, latched data reads return zero and table write commands are dropped. Neither is forwarded.
- R11: Reset puts the block in `ST_PASS` and clears the stored address and stored data to zero.
- R12: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = full 32-bit access |
| req_addr | input | WIN_AW | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request rejected (R9) |
| rsp_rdata | output | 32 | Read response data |
| ds_valid | output | 1 | Forwarded access strobe |
| ds_write | output | 1 | Forwarded access is a write |
| ds_addr | output | WIN_AW | Forwarded window offset |
| ds_wdata | output | 32 | Forwarded write data |
| ds_rdata | input | 32 | Downstream read data, same cycle |
| tbl_present | input | 1 | A vector table is attached |
| tbl_we | output | 1 | Table write strobe |
| tbl_re | output | 1 | Table read strobe |
| tbl_idx | output | TBL_IDX_W | Table entry index |
| tbl_wdata | output | 32 | Table write data |
| tbl_rdata | input | 32 | Table read data, same cycle |

## Verification
The bench builds the block with its defaults: a 3-bit window offset and a 12-bit table index. This lets it write, and read back, both the first entry (index 0) and the last entry (index 0xFFF) of a full 4096-entry table model, and it covers every misaligned byte offset inside the window. With the 3-bit offset, all eight offsets can be reached, so each of the six misaligned ones can be issued to hit the R9 rejection. The 12-bit index also places the ignored bits 15:12 directly above it. The bench sets those bits in claim words, which shows they neither change the type match nor leak into the index.

// File: rtl/idx_tbl_pkg.sv
package idx_tbl_pkg;

    localparam int WORD_W   = 32;
    localparam int TYPE_LSB = 16;
    localparam int TYPE_MSB = 30;
    localparam int CMD_BIT  = 31;
    localparam int TYPE_W   = TYPE_MSB - TYPE_LSB + 1;
    localparam logic [TYPE_W-1:0] TABLE_TYPE = TYPE_W'(1);

    typedef enum logic {
        ST_PASS,
        ST_LATCHED
    } win_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BAD,
        OP_WR_DATA,
        OP_WR_ADDR,
        OP_RD_DATA,
        OP_RD_ADDR
    } win_op_e;

    function automatic logic names_table(input logic [WORD_W-1:0] w);
        return w[TYPE_MSB:TYPE_LSB] == TABLE_TYPE;
    endfunction

endpackage

// File: rtl/idx_tbl_decode.sv
module idx_tbl_decode
    import idx_tbl_pkg::*;
#(
    parameter int WIN_AW = 3
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_full,
    input  logic [WIN_AW-1:0] req_addr,
    output win_op_e           op
);

    localparam int LANE_BITS = 2;
    localparam int REG_BIT   = LANE_BITS;
    localparam int WIN_BITS  = LANE_BITS + 1;

    logic aligned;
    logic in_window;

    always_comb begin
        aligned   = req_full && (req_addr[LANE_BITS-1:0] == '0);
        in_window = (req_addr >> WIN_BITS) == '0;
        if (!req_valid) begin
            op = OP_NONE;
        end else if (!aligned || !in_window) begin
            op = OP_BAD;
        end else if (req_write) begin
            op = req_addr[REG_BIT] ? OP_WR_ADDR : OP_WR_DATA;
        end else begin
            op = req_addr[REG_BIT] ? OP_RD_ADDR : OP_RD_DATA;
        end
    end

endmodule

// File: rtl/idx_tbl_ctrl.sv
module idx_tbl_ctrl
    import idx_tbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  win_op_e           op,
    input  logic [WORD_W-1:0] req_wdata,
    output win_state_e        state,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] data_q
);

    win_state_e state_nxt;

    // claim / release / hold
    always_comb begin
        state_nxt = state;
        unique case (op)
            OP_WR_ADDR: state_nxt = names_table(req_wdata) ? ST_LATCHED : ST_PASS;
            default:    state_nxt = state;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PASS;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (op == OP_WR_DATA) begin
                data_q <= req_wdata;
            end
            if (op == OP_WR_ADDR && names_table(req_wdata)) begin
                addr_q <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/idx_tbl_route.sv
module idx_tbl_route
    import idx_tbl_pkg::*;
#(
    parameter int WIN_AW    = 3,
    parameter int TBL_IDX_W = 12
) (
    input  win_op_e              op,
    input  win_state_e           state,
    input  logic [WIN_AW-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    input  logic [WORD_W-1:0]    addr_q,
    input  logic [WORD_W-1:0]    data_q,
    input  logic                 tbl_present,
    input  logic [WORD_W-1:0]    ds_rdata,
    input  logic [WORD_W-1:0]    tbl_rdata,
    output logic                 ds_valid,
    output logic                 ds_write,
    output logic [WIN_AW-1:0]    ds_addr,
    output logic [WORD_W-1:0]    ds_wdata,
    output logic                 tbl_we,
    output logic                 tbl_re,
    output logic [TBL_IDX_W-1:0] tbl_idx,
    output logic [WORD_W-1:0]    tbl_wdata,
    output logic [WORD_W-1:0]    rd_data
);

    localparam logic [WORD_W-1:0] CMD_FLIP = WORD_W'(1) << CMD_BIT;

    always_comb begin
        ds_valid  = 1'b0;
        ds_write  = 1'b0;
        ds_addr   = req_addr;
        ds_wdata  = req_wdata;
        tbl_we    = 1'b0;
        tbl_re    = 1'b0;
        tbl_idx   = addr_q[TBL_IDX_W-1:0];
        tbl_wdata = data_q;
        rd_data   = '0;
        unique case (op)
            OP_WR_DATA: begin
                ds_valid = 1'b1;
                ds_write = 1'b1;
            end
            OP_WR_ADDR: begin
                if (names_table(req_wdata) && req_wdata[CMD_BIT]) begin
                    tbl_idx = req_wdata[TBL_IDX_W-1:0];
                    tbl_we  = tbl_present;
                end else begin
                    ds_valid = 1'b1;
                    ds_write = 1'b1;
                end
            end
            OP_RD_ADDR: begin
                if (state == ST_LATCHED) begin
                    rd_data = addr_q ^ CMD_FLIP;
                end else begin
                    ds_valid = 1'b1;
                    rd_data  = ds_rdata;
                end
            end
            OP_RD_DATA: begin
                if (state == ST_LATCHED) begin
                    tbl_re  = tbl_present;
                    rd_data = tbl_present ? tbl_rdata : '0;
                end else begin
                    ds_valid = 1'b1;
                    rd_data  = ds_rdata;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/idx_tbl_window.sv
module idx_tbl_window
    import idx_tbl_pkg::*;
#(
    parameter int WIN_AW    = 3,
    parameter int TBL_IDX_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_full,
    input  logic [WIN_AW-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    output logic                 ds_valid,
    output logic                 ds_write,
    output logic [WIN_AW-1:0]    ds_addr,
    output logic [31:0]          ds_wdata,
    input  logic [31:0]          ds_rdata,
    input  logic                 tbl_present,
    output logic                 tbl_we,
    output logic                 tbl_re,
    output logic [TBL_IDX_W-1:0] tbl_idx,
    output logic [31:0]          tbl_wdata,
    input  logic [31:0]          tbl_rdata
);

    win_op_e           op;
    win_state_e        cur_state;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] rd_data;

    idx_tbl_decode #(.WIN_AW(WIN_AW)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_full  (req_full),
        .req_addr  (req_addr),
        .op        (op)
    );

    idx_tbl_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .req_wdata (req_wdata),
        .state     (cur_state),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    idx_tbl_route #(.WIN_AW(WIN_AW), .TBL_IDX_W(TBL_IDX_W)) u_route (
        .op          (op),
        .state       (cur_state),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .addr_q      (addr_q),
        .data_q      (data_q),
        .tbl_present (tbl_present),
        .ds_rdata    (ds_rdata),
        .tbl_rdata   (tbl_rdata),
        .ds_valid    (ds_valid),
        .ds_write    (ds_write),
        .ds_addr     (ds_addr),
        .ds_wdata    (ds_wdata),
        .tbl_we      (tbl_we),
        .tbl_re      (tbl_re),
        .tbl_idx     (tbl_idx),
        .tbl_wdata   (tbl_wdata),
        .rd_data     (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (op != OP_NONE);
            rsp_err   <= (op == OP_BAD);
            rsp_rdata <= rd_data;
        end
    end

endmodule

// File: rtl/idx_tbl_window_chk.sv
module idx_tbl_window_chk
    import idx_tbl_pkg::*;
#(
    parameter int WIN_AW    = 3,
    parameter int TBL_IDX_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_full,
    input logic [WIN_AW-1:0]    req_addr,
    input logic [31:0]          req_wdata,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [31:0]          rsp_rdata,
    input logic                 ds_valid,
    input logic                 tbl_present,
    input logic                 tbl_we,
    input logic                 tbl_re,
    input logic [TBL_IDX_W-1:0] tbl_idx,
    input win_state_e           cur_state,
    input logic [31:0]          addr_q
);

    localparam logic [WIN_AW-1:0] ADDR_OFS = WIN_AW'(4);

    logic bad_req;
    logic cmd_req;
    logic rd_addr_lat;

    assign bad_req     = req_valid && (!req_full || req_addr[1:0] != 2'b00);
    assign cmd_req     = req_valid && req_write && req_full && req_addr == ADDR_OFS &&
                         req_wdata[30:16] == 15'd1 && req_wdata[31];
    assign rd_addr_lat = req_valid && !req_write && req_full && req_addr == ADDR_OFS &&
                         cur_state == ST_LATCHED;

    a_r3_cmd_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> !ds_valid);

    a_r3_cmd_table_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && tbl_present) |-> (tbl_we && tbl_idx == req_wdata[TBL_IDX_W-1:0]));

    a_r9_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> (!ds_valid && !tbl_we && !tbl_re));

    a_r9_bad_err_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> (rsp_err && rsp_rdata == 32'd0));

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r5_latch_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_lat |=> (rsp_rdata == ($past(addr_q) ^ 32'h8000_0000)));

    a_r10_no_table_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_present |-> (!tbl_we && !tbl_re));

endmodule

bind idx_tbl_window idx_tbl_window_chk #(.WIN_AW(WIN_AW), .TBL_IDX_W(TBL_IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_full    (req_full),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .ds_valid    (ds_valid),
    .tbl_present (tbl_present),
    .tbl_we      (tbl_we),
    .tbl_re      (tbl_re),
    .tbl_idx     (tbl_idx),
    .cur_state   (cur_state),
    .addr_q      (addr_q)
);

// File: tb/sim_idx_tbl_window.sv
module sim_idx_tbl_window;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 3;
    localparam int IW         = 12;
    localparam int DEPTH      = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_full = 1'b1;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic          ds_valid, ds_write;
    logic [AW-1:0] ds_addr;
    logic [31:0]   ds_wdata, ds_rdata;
    logic          tbl_present = 1'b1;
    logic          tbl_we, tbl_re;
    logic [IW-1:0] tbl_idx;
    logic [31:0]   tbl_wdata, tbl_rdata;

    logic [31:0] tbl_mem [DEPTH];
    logic [31:0] exp_mem [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    bit          m_lat  = 0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ds_rdata  = 32'hD5A0_0000 | {29'd0, ds_addr};
    assign tbl_rdata = tbl_mem[tbl_idx];

    always @(posedge clk) begin
        if (tbl_we) tbl_mem[tbl_idx] <= tbl_wdata;
    end

    idx_tbl_window #(.WIN_AW(AW), .TBL_IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ds_valid(ds_valid), .ds_write(ds_write), .ds_addr(ds_addr),
        .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .tbl_present(tbl_present), .tbl_we(tbl_we), .tbl_re(tbl_re),
        .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    function automatic logic [31:0] seed_entry(input int i);
        return (32'(i) * 32'h0000_9E37) ^ 32'h5A5A_0000;
    endfunction

    function automatic bit is_tbl_type(input logic [31:0] w);
        return w[30:16] == 15'd1;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        m_lat = 0; m_addr = '0; m_data = '0;
        chk(rsp_valid == 1'b0, "R11 rsp idle in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one access; starts and ends at a falling edge
    task automatic access(input bit wr, input logic [AW-1:0] a, input bit full,
                          input logic [31:0] wd, input string rq);
        bit          bad;
        bit          exp_fwd, exp_twe, exp_tre;
        logic [31:0] exp_rd;
        logic [11:0] widx;
        bad     = !full || a[1:0] != 2'b00;
        exp_fwd = 0; exp_twe = 0; exp_tre = 0; exp_rd = '0; widx = '0;
        if (!bad) begin
            if (wr && a[2] == 1'b0) begin
                exp_fwd = 1;
            end else if (wr) begin
                if (is_tbl_type(wd) && wd[31]) begin
                    exp_twe = tbl_present;
                    widx = wd[11:0];
                end else begin
                    exp_fwd = 1;
                end
            end else if (!m_lat) begin
                exp_fwd = 1;
                exp_rd  = 32'hD5A0_0000 | {29'd0, a};
            end else if (a[2]) begin
                exp_rd = m_addr ^ 32'h8000_0000;
            end else begin
                exp_tre = tbl_present;
                exp_rd  = tbl_present ? exp_mem[m_addr[11:0]] : 32'd0;
            end
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_full = full; req_wdata = wd;
        #1;
        chk(ds_valid == exp_fwd, {rq, " forward"}, 32'(ds_valid), 32'(exp_fwd));
        chk(tbl_we == exp_twe, {rq, " table write strobe"}, 32'(tbl_we), 32'(exp_twe));
        chk(tbl_re == exp_tre, {rq, " table read strobe"}, 32'(tbl_re), 32'(exp_tre));
        if (exp_fwd && wr)
            chk(ds_write && ds_wdata == wd && ds_addr == a, {rq, " forwarded write"}, ds_wdata, wd);
        if (exp_twe)
            chk(tbl_idx == widx && tbl_wdata == m_data, {rq, " table write data"}, tbl_wdata, m_data);
        @(posedge clk);
        if (!bad && wr) begin
            if (a[2] == 1'b0) begin
                m_data = wd;
            end else if (is_tbl_type(wd)) begin
                m_lat = 1; m_addr = wd;
                if (wd[31] && tbl_present) exp_mem[wd[11:0]] = m_data;
            end else begin
                m_lat = 0;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {rq, " R12 response"}, 32'(rsp_valid), 1);
        chk(rsp_err == bad, {rq, " R9 error flag"}, 32'(rsp_err), 32'(bad));
        if (!wr || bad)
            chk(rsp_rdata == exp_rd, {rq, " read data"}, rsp_rdata, exp_rd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd61101));
        for (int i = 0; i < DEPTH; i++) begin
            tbl_mem[i] = seed_entry(i);
            exp_mem[i] = seed_entry(i);
        end
        @(negedge clk);
        do_reset();

        // R11: after reset the block passes through, stored data is zero
        access(0, 3'd4, 1, 0, "R11 read addr after reset");
        access(0, 3'd0, 1, 0, "R11 read data after reset");
        access(1, 3'd4, 1, 32'h8001_0002, "R11 cmd with cleared data");
        access(0, 3'd0, 1, 0, "R11 R6 cleared data landed");

        // R7, R2, R1 (mask bits 15:12 ignored)
        access(1, 3'd0, 1, 32'hCAFE_0001, "R7 data write");
        access(1, 3'd4, 1, 32'h0001_F005, "R2 R1 claim with mask bits");
        access(0, 3'd4, 1, 0, "R5 latched addr readback");
        access(0, 3'd0, 1, 0, "R6 latched data read");
        // R3 at highest index
        access(1, 3'd4, 1, 32'h8001_0FFF, "R3 cmd at last index");
        access(0, 3'd0, 1, 0, "R3 R6 last index read back");
        access(0, 3'd4, 1, 0, "R5 readback after cmd");
        access(1, 3'd0, 1, 32'h1234_5678, "R7 data write 2");
        access(1, 3'd4, 1, 32'h8001_0000, "R3 cmd at index 0");
        access(0, 3'd0, 1, 0, "R3 index 0 read back");
        // R9: every misaligned offset and a sub-word access
        for (int k = 1; k < 8; k++) begin
            if (k != 4) access(k[0], 3'(k), 1, 32'hFFFF_FFFF, "R9 misaligned");
        end
        access(1, 3'd0, 0, 32'hDEAD_BEEF, "R9 sub-word data write");
        access(1, 3'd4, 0, 32'h0002_0000, "R9 sub-word addr write");
        access(0, 3'd4, 1, 0, "R9 state unchanged");
        access(1, 3'd4, 1, 32'h8001_0010, "R9 data unchanged via cmd");
        access(0, 3'd0, 1, 0, "R9 stored data check");
        // R4, R8
        access(1, 3'd4, 1, 32'h8002_0010, "R4 release other type");
        access(0, 3'd0, 1, 0, "R8 pass data read");
        access(0, 3'd4, 1, 0, "R8 pass addr read");
        // R10
        tbl_present = 1'b0;
        access(1, 3'd4, 1, 32'h0001_0003, "R10 claim without table");
        access(0, 3'd0, 1, 0, "R10 data read zero");
        access(1, 3'd4, 1, 32'h8001_0003, "R10 cmd dropped");
        tbl_present = 1'b1;
        access(0, 3'd0, 1, 0, "R10 entry unchanged");
        // R11 mid-stream reset
        do_reset();
        access(0, 3'd4, 1, 0, "R11 pass after reset");

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a;
            logic [31:0]   wd;
            bit            wr, full;
            int            r;
            r = int'($urandom % 10);
            a = (r == 0) ? 3'($urandom % 8) : ((($urandom % 2) == 0) ? 3'd0 : 3'd4);
            wr   = ($urandom % 2) == 1;
            full = ($urandom % 12) != 0;
            wd   = $urandom;
            if (a == 3'd4 && ($urandom % 5) != 0) begin
                wd[30:16] = 15'd1;
                r = int'($urandom % 8);
                if (r == 0) wd[11:0] = 12'h000;
                if (r == 1) wd[11:0] = 12'hFFF;
            end
            if (($urandom % 10) == 0) tbl_present = ($urandom % 4) != 0;
            access(wr, a, full, wd, "R2 R3 R4 R5 R6 R7 R8 R10 random");
        end
        summary();
    end

endmodule